// File: doc/BRIEF.md
# Strided Vector Memory Mover

This block transfers a single vector between a word-addressed memory and one register of a vector register file. The memory is split into interleaved banks, and the block holds that storage itself. A command gives the direction, a base word address, a signed word stride, an element count and a register index. After it accepts the command, the block forms one element address per cycle by adding the stride to the previous address. It issues the elements strictly in ascending order.

The memory has a single port, so at most one element is accessed in any cycle. The low bits of the word address select the bank. After each access that bank stays occupied for a fixed number of processor cycles. Each bank has its own countdown timer, and issue waits whenever the bank of the next element is still counting. The timers keep running across commands, so a command that follows another closely can stall on banks the previous command left occupied.

The register file is outside the block and is reached through one port. For a store, the block names a register and element, and the read data comes back in the same cycle. For a load, the block writes an element one cycle after it is issued.

Top module: `vec_strided_mover`

## Requirements
- R1: While reset is asserted and after it is released with no command, `busy`, `done`, `vr_re` and `vr_we` are all low.
- R2: A command is accepted when `start` is high, `busy` is low and `start_len` is in the range 1 to MAX_LEN. `busy` is high from the next cycle. Exactly `start_len` elements are moved. Element i uses word address (base + i*stride) modulo 2^ADDR_W.
- R3: The bank of an access is given by the low log2(NBANK) bits of its word address. A bank accessed in cycle t is not accessed again before cycle t+BANK_CYC (4 by default).
- R4: At most one element issues per cycle, in ascending element order. The first element issues no earlier than the cycle after acceptance, and each later element issues no earlier than the cycle after the previous one. Each element issues in the earliest such cycle in which its bank is free.
- R5: `start_store` = 1 selects a store. In the issue cycle of element i, `vr_re` is high, `vr_elem` is i and `vr_reg` is the command's register. `vr_rdata` is then written to the element's memory word.
- R6: `start_store` = 0 selects a load. In the cycle after element i issues, `vr_we` is high, `vr_elem` is i, `vr_reg` is the command's register and `vr_wdata` is the memory word at the element's address.
- R7: `done` is high for exactly one cycle per accepted command. For a store, it is the cycle after the last element issues. For a load, it is the cycle after the last register write. `busy` is low in that cycle, so a new command can be accepted in it.
- R8: The stride is a two's complement word offset, and addresses wrap modulo 2^ADDR_W. A stride of 0 touches one word every BANK_CYC cycles.
- R9: A `start` pulse while `busy` is high is ignored: no extra `done` is produced and no memory word or register element is touched.
- R10: A `start` with `start_len` equal to 0 or above MAX_LEN is ignored: `busy` stays low and no access or `done` follows.
- R11: Bank timers persist across commands. A command accepted in a `done` cycle stalls on any bank still occupied by the previous command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request |
| start_store | input | 1 | 1 = store (register to memory), 0 = load |
| start_base | input | ADDR_W | Base word address |
| start_stride | input | ADDR_W | Signed word stride |
| start_len | input | LEN_W | Element count, 1 to MAX_LEN |
| start_vreg | input | REG_W | Vector register index |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| vr_re | output | 1 | Register element read strobe (store) |
| vr_we | output | 1 | Register element write strobe (load) |
| vr_reg | output | REG_W | Register index for read or write |
| vr_elem | output | IDX_W | Element index for read or write |
| vr_wdata | output | DATA_W | Load data to the register file |
| vr_rdata | input | DATA_W | Store data from the register file, same cycle |

## Verification
A wrong address register or stride sign shows up within one element. A later load then returns the wrong word, or a store writes somewhere a full-memory read-back exposes. A wrong bank timer shifts the cycle of the very next `vr_re` or `vr_we` strobe against the arithmetically derived schedule, and stride 0, 8 and 16 make such an error show in every element. A wrong element counter or end condition moves the `done` cycle or changes the strobe count at the end of that same command.

// File: rtl/vec_strided_mover.sv
module vec_strided_mover #(
  parameter int DATA_W   = 64,
  parameter int MAX_LEN  = 64,
  parameter int NBANK    = 16,
  parameter int BANK_CYC = 4,
  parameter int ADDR_W   = 10,
  parameter int NREG     = 8,
  localparam int IDX_W   = $clog2(MAX_LEN),
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int REG_W   = $clog2(NREG),
  localparam int BSEL_W  = $clog2(NBANK),
  localparam int TMR_W   = $clog2(BANK_CYC + 1),
  localparam int DEPTH   = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_store,
  input  logic [ADDR_W-1:0] start_base,
  input  logic [ADDR_W-1:0] start_stride,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [REG_W-1:0]  start_vreg,
  output logic              busy,
  output logic              done,
  output logic              vr_re,
  output logic              vr_we,
  output logic [REG_W-1:0]  vr_reg,
  output logic [IDX_W-1:0]  vr_elem,
  output logic [DATA_W-1:0] vr_wdata,
  input  logic [DATA_W-1:0] vr_rdata
);

  logic              run, is_st, ld_v, ld_last, done_q;
  logic [ADDR_W-1:0] addr_q, step_q;
  logic [IDX_W-1:0]  idx_q, ld_idx;
  logic [LEN_W-1:0]  len_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] ld_dat;
  logic [TMR_W-1:0]  tmr [NBANK];
  logic [DATA_W-1:0] mem [DEPTH];

  wire [BSEL_W-1:0] bank   = addr_q[BSEL_W-1:0];
  wire              go     = run && (tmr[bank] == '0);
  wire              last   = (LEN_W'(idx_q) + LEN_W'(1)) == len_q;
  wire              len_ok = (start_len != '0) && (int'(start_len) <= MAX_LEN);
  wire              accept = start && !busy && len_ok;

  assign busy     = run || ld_v;
  assign done     = done_q;
  assign vr_re    = go && is_st;
  assign vr_we    = ld_v;
  assign vr_reg   = reg_q;
  assign vr_elem  = is_st ? idx_q : ld_idx;
  assign vr_wdata = ld_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      ld_v    <= 1'b0;
      ld_last <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q  <= (go && last && is_st) || (ld_v && ld_last);
      ld_v    <= go && !is_st;
      ld_last <= go && last;
      if (accept)          run <= 1'b1;
      else if (go && last) run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) tmr[b] <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (go && bank == BSEL_W'(b)) tmr[b] <= TMR_W'(BANK_CYC - 1);
        else if (tmr[b] != '0)        tmr[b] <= tmr[b] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      is_st  <= start_store;
      addr_q <= start_base;
      step_q <= start_stride;
      len_q  <= start_len;
      reg_q  <= start_vreg;
      idx_q  <= '0;
    end else if (go) begin
      addr_q <= addr_q + step_q;
      idx_q  <= idx_q + 1'b1;
    end
    if (go && is_st) mem[addr_q] <= vr_rdata;
    if (go && !is_st) begin
      ld_dat <= mem[addr_q];
      ld_idx <= idx_q;
    end
  end

  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vr_re && vr_we));

  // R3
  bank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && $past(go)) |-> bank != $past(bank));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !len_ok) |=> !busy);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(go && last && is_st) && !(ld_v && ld_last)) |=> busy);

endmodule

// File: tb/sim_vec_strided_mover.sv
`timescale 1ns/1ps
module sim_vec_strided_mover;
  localparam int AW = 8, DW = 64, ML = 64, NB = 16, BC = 4, NR = 8;
  localparam int LW = 7, IW = 6, RW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, start_store = 1'b0;
  logic [AW-1:0] start_base = '0, start_stride = '0;
  logic [LW-1:0] start_len = '0;
  logic [RW-1:0] start_vreg = '0;
  logic busy, done, vr_re, vr_we;
  logic [RW-1:0] vr_reg;
  logic [IW-1:0] vr_elem;
  logic [DW-1:0] vr_wdata, vr_rdata;

  always #4 clk = ~clk;

  vec_strided_mover #(.DATA_W(DW), .MAX_LEN(ML), .NBANK(NB), .BANK_CYC(BC),
                      .ADDR_W(AW), .NREG(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_store(start_store),
    .start_base(start_base), .start_stride(start_stride), .start_len(start_len),
    .start_vreg(start_vreg), .busy(busy), .done(done), .vr_re(vr_re), .vr_we(vr_we),
    .vr_reg(vr_reg), .vr_elem(vr_elem), .vr_wdata(vr_wdata), .vr_rdata(vr_rdata));

  function automatic logic [63:0] vdata(int r, int e);
    return 64'(r) * 64'h0100_0000_0000_0000 + 64'(e) * 64'h0000_0101_0003_0007
           + 64'h00C0_FFEE_0000_0000;
  endfunction

  assign vr_rdata = vdata(int'(vr_reg), int'(vr_elem));

  int cyc = 0, n_chk = 0, n_bad = 0, n_done = 0, n_acc = 0;
  int re_cyc [64];
  int we_cyc [64];
  logic [63:0] we_dat [64];
  int n_re = 0, n_we = 0, reg_bad = 0, exp_reg = 0;
  logic [63:0] mem_ref [256];
  int bfree [16];

  always @(posedge clk) begin
    if (vr_re === 1'b1) begin
      re_cyc[vr_elem] = cyc; n_re++;
      if (int'(vr_reg) != exp_reg) reg_bad++;
    end
    if (vr_we === 1'b1) begin
      we_cyc[vr_elem] = cyc; we_dat[vr_elem] = vr_wdata; n_we++;
      if (int'(vr_reg) != exp_reg) reg_bad++;
    end
    if (done === 1'b1) n_done++;
    cyc++;
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(bit st, int base, int stride, int len, int r, bit poke);
    int t, a, wd, c0, dcyc;
    int exp_t [64];
    int exp_a [64];
    for (int i = 0; i < 64; i++) begin re_cyc[i] = -1; we_cyc[i] = -1; end
    n_re = 0; n_we = 0; reg_bad = 0; exp_reg = r;
    c0 = cyc;
    start = 1'b1; start_store = st; start_base = AW'(base);
    start_stride = AW'(stride); start_len = LW'(len); start_vreg = RW'(r);
    t = c0;
    for (int i = 0; i < len; i++) begin
      a = (((base + i * stride) % 256) + 256) % 256;
      t = (t + 1 > bfree[a % 16]) ? t + 1 : bfree[a % 16];
      bfree[a % 16] = t + BC;
      exp_t[i] = t; exp_a[i] = a;
    end
    @(negedge clk);
    start = 1'b0;
    check("R2", "busy after accept", 64'(busy), 64'(1));
    wd = 0;
    while (done !== 1'b1 && wd < 3000) begin
      if (poke && wd == 1) begin
        start = 1'b1; start_store = 1'b1; start_base = '0;
        start_stride = AW'(1); start_len = LW'(64); start_vreg = RW'(7);
      end else if (poke && wd == 2) start = 1'b0;
      @(negedge clk);
      wd++;
    end
    dcyc = cyc;
    n_acc++;
    check("R7", "done cycle", 64'(dcyc), 64'(exp_t[len-1] + (st ? 1 : 2)));
    check("R7", "busy low at done", 64'(busy), 64'(0));
    check("R5", "register index", 64'(reg_bad), 64'(0));
    if (st) begin
      check("R2", "store strobe count", 64'(n_re), 64'(len));
      for (int i = 0; i < len; i++) begin
        check(poke ? "R9" : "R4", "store issue cycle", 64'(re_cyc[i]), 64'(exp_t[i]));
        mem_ref[exp_a[i]] = vdata(r, i);
      end
    end else begin
      check("R2", "load strobe count", 64'(n_we), 64'(len));
      for (int i = 0; i < len; i++) begin
        check("R4", "load write cycle", 64'(we_cyc[i]), 64'(exp_t[i] + 1));
        check(stride <= 0 ? "R8" : "R6", "load data", we_dat[i], mem_ref[exp_a[i]]);
      end
    end
  endtask

  task automatic try_bad(int len);
    start = 1'b1; start_store = 1'b1; start_base = AW'(3);
    start_stride = AW'(1); start_len = LW'(len); start_vreg = RW'(7);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      check("R10", "busy stays low", 64'(busy), 64'(0));
      check("R10", "no strobe", 64'({vr_re, vr_we, done}), 64'(0));
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int b = 0; b < 16; b++) bfree[b] = 0;
    repeat (4) @(negedge clk);
    // R1
    check("R1", "reset outputs", 64'({busy, done, vr_re, vr_we}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle outputs", 64'({busy, done, vr_re, vr_we}), 64'(0));
    for (int q = 0; q < 4; q++) run_op(1'b1, q * 64, 1, 64, q, 1'b0);
    run_op(1'b0, 0, 1, 64, 4, 1'b0);
    run_op(1'b0, 5, 2, 33, 5, 1'b0);
    run_op(1'b0, 3, 3, 17, 6, 1'b0);
    run_op(1'b0, 250, -1, 64, 0, 1'b0);   // R8 negative wrap
    run_op(1'b0, 7, 16, 10, 1, 1'b0);     // R3 same bank
    run_op(1'b0, 9, 8, 20, 2, 1'b0);
    run_op(1'b0, 40, 0, 6, 3, 1'b0);      // R8 stride zero
    run_op(1'b0, 100, -5, 64, 4, 1'b0);
    run_op(1'b0, 0, 17, 15, 5, 1'b0);
    run_op(1'b0, 1, 4, 1, 6, 1'b0);
    run_op(1'b1, 10, 0, 5, 6, 1'b0);      // R11 back-to-back stall follows
    run_op(1'b0, 10, 0, 3, 1, 1'b0);
    run_op(1'b1, 200, -3, 40, 5, 1'b1);   // R9 poke during store
    run_op(1'b0, 30, 7, 30, 2, 1'b1);     // R9 poke during load
    for (int q = 0; q < 4; q++) run_op(1'b0, q * 64, 1, 64, q + 4, 1'b0);
    try_bad(0);
    try_bad(65);
    run_op(1'b0, 12, 16, 4, 0, 1'b0);
    repeat (8) @(negedge clk);
    check("R9", "done pulses vs accepted", 64'(n_done), 64'(n_acc));
    finish_run();
  end
endmodule